// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block supplies operand addresses to a DSP datapath. It holds a set of address pointers, a set of signed modify (step) values and a set of per-pointer buffer lengths. On an access strobe the selected pointer drives the address output in the same cycle. At the clock edge that closes the cycle, the pointer is stepped by whichever modify register the access selects. Pointer select and modify select are independent.

A nonzero length turns the pointer into a circular-buffer index. The buffer base is the value last written to that pointer, and the update wraps so the pointer stays inside base .. base+length-1. A zero length gives plain linear stepping, which wraps around the address space. Software loads and inspects all registers through a write port and a combinational read port. When a pointer load and an access to the same pointer fall in one cycle, the load takes priority.

Top module: `dag_circ_addr_gen`

## Requirements
- R1: After reset every pointer, modify and length register reads back as zero.
- R2: While acc_en is high, addr_out shows the selected pointer's value from before the update. The pointer takes its new value at the next rising clock edge.
- R3: The update adds the modify register chosen by acc_mod, a 14-bit two's-complement value, independently of acc_ptr.
- R4: With a length of zero the update is linear and wraps modulo 2^14 (0x3FFF+1 gives 0, and 0-3 gives 0x3FFD).
- R5: With a nonzero length L and a non-negative modify, a sum at or above base+L is reduced by L.
- R6: With a nonzero length L and a negative modify, a sum below base is increased by L.
- R7: A pointer write sets both the pointer and its buffer base to the written value. Length writes and pointer updates leave the base unchanged.
- R8: A pointer write in the same cycle as an access to that pointer wins: the pointer takes the written value.
- R9: A pointer write and an access to a different pointer in the same cycle both take effect.
- R10: Without an access or a write, registers hold their values. Register bank codes are 0 pointer, 1 modify, 2 length and 3 none. A read of bank 3 returns zero, and a write to bank 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank for the write (0 pointer, 1 modify, 2 length, 3 none) |
| wr_idx | input | 2 | Register index for the write |
| wr_data | input | 14 | Write data |
| rd_bank | input | 2 | Bank for the read |
| rd_idx | input | 2 | Register index for the read |
| rd_data | output | 14 | Combinational read data |
| acc_en | input | 1 | Indirect access strobe |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Modify register used by the access |
| addr_out | output | 14 | Address: selected pointer before the update |

## Verification
The bench uses the default 14-bit address width and four registers per bank. With these values the top of the address space is reachable, so linear stepping can be seen crossing 0x3FFF to 0 and back. A buffer of length 8 is stepped by +3 and -3, which drives both wrap directions. A second buffer of length 5 is set up after its pointer was loaded, which shows that the base is fixed at load time. Same-cycle write and access, on the same pointer and on different pointers, exercise the priority rule.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    BANK_PTR  = 2'd0,
    BANK_MOD  = 2'd1,
    BANK_LEN  = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;
endpackage

// File: rtl/dag_wrap_unit.sv
module dag_wrap_unit #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum, bse, lenx, lim, wrap_dn, wrap_up;

  always_comb begin
    sum     = $signed({2'b00, ptr}) + $signed({{2{modv[AW-1]}}, modv});
    bse     = $signed({2'b00, base});
    lenx    = $signed({2'b00, len});
    lim     = bse + lenx;
    wrap_dn = sum - lenx;
    wrap_up = sum + lenx;
    if (len == '0) begin
      nxt = sum[AW-1:0];
    end else if (!modv[AW-1] && (sum >= lim)) begin
      nxt = wrap_dn[AW-1:0];
    end else if (modv[AW-1] && (sum < bse)) begin
      nxt = wrap_up[AW-1:0];
    end else begin
      nxt = sum[AW-1:0];
    end
  end
endmodule

// File: rtl/dag_reg_bank.sv
module dag_reg_bank #(
  parameter int N = 4,
  parameter int W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] widx,
  input  logic [W-1:0]         wdata,
  output logic [N-1:0][W-1:0]  q
);
  localparam int IW = $clog2(N);

  logic [N-1:0][W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt[widx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_hold
    // R10: a register not addressed by a write keeps its value
    a_r10_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (widx == IW'(i))) |=> $stable(q[i]));
  end
endmodule

// File: rtl/dag_ptr_slot.sv
module dag_ptr_slot #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          upd,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] base, ptr_nxt, base_nxt, step_val;

  dag_wrap_unit #(.AW(AW)) u_wrap (
    .ptr  (ptr),
    .base (base),
    .modv (modv),
    .len  (len),
    .nxt  (step_val)
  );

  always_comb begin
    ptr_nxt  = ptr;
    base_nxt = base;
    if (load) begin
      ptr_nxt  = load_val;
      base_nxt = load_val;
    end else if (upd) begin
      ptr_nxt  = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      base <= '0;
    end else begin
      ptr  <= ptr_nxt;
      base <= base_nxt;
    end
  end

  logic          in_buf, step_small;
  logic [AW-1:0] mag;
  always_comb begin
    in_buf     = ({1'b0, ptr} >= {1'b0, base}) &&
                 ({1'b0, ptr} < ({1'b0, base} + {1'b0, len}));
    mag        = modv[AW-1] ? (~modv + 1'b1) : modv;
    step_small = mag < len;
  end

  // R8: a load overrides any update in the same cycle
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_val)));
  // R5: a pointer inside its buffer stays inside after a short step
  a_r5_stay_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load && (len != '0) && in_buf && step_small) |=> in_buf);
  // R4: zero length gives linear stepping
  a_r4_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !load && (len == '0)) |=> (ptr == AW'($past(ptr) + $past(modv))));
  // R10: idle pointer holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !load) |=> $stable(ptr));
endmodule

// File: rtl/dag_circ_addr_gen.sv
module dag_circ_addr_gen #(
  parameter int AW   = 14,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_bank,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [AW-1:0]           wr_data,
  input  logic [1:0]              rd_bank,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [AW-1:0]           rd_data,
  input  logic                    acc_en,
  input  logic [$clog2(NREG)-1:0] acc_ptr,
  input  logic [$clog2(NREG)-1:0] acc_mod,
  output logic [AW-1:0]           addr_out
);
  import dag_pkg::*;
  localparam int IW = $clog2(NREG);

  bank_e wbank, rbank;
  assign wbank = bank_e'(wr_bank);
  assign rbank = bank_e'(rd_bank);

  logic [NREG-1:0][AW-1:0] mod_q, len_q, ptr_q;
  logic [NREG-1:0]         load_v;
  logic [AW-1:0]           sel_mod;

  dag_reg_bank #(.N(NREG), .W(AW)) u_mod_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && (wbank == BANK_MOD)), .widx(wr_idx), .wdata(wr_data),
    .q(mod_q)
  );

  dag_reg_bank #(.N(NREG), .W(AW)) u_len_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && (wbank == BANK_LEN)), .widx(wr_idx), .wdata(wr_data),
    .q(len_q)
  );

  assign sel_mod = mod_q[acc_mod];

  for (genvar i = 0; i < NREG; i++) begin : g_ptr
    assign load_v[i] = wr_en && (wbank == BANK_PTR) && (wr_idx == IW'(i));
    dag_ptr_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_v[i]),
      .load_val (wr_data),
      .upd      (acc_en && (acc_ptr == IW'(i))),
      .modv     (sel_mod),
      .len      (len_q[i]),
      .ptr      (ptr_q[i])
    );
  end

  assign addr_out = ptr_q[acc_ptr];

  always_comb begin
    case (rbank)
      BANK_PTR: rd_data = ptr_q[rd_idx];
      BANK_MOD: rd_data = mod_q[rd_idx];
      BANK_LEN: rd_data = len_q[rd_idx];
      default:  rd_data = '0;
    endcase
  end

  // R3: linear access advances the accessed pointer by the chosen modify value
  a_r3_mod_select: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !load_v[acc_ptr] && (len_q[acc_ptr] == '0))
      |=> (ptr_q[$past(acc_ptr)] == AW'($past(addr_out) + $past(sel_mod))));
endmodule

// File: tb/tb_dag_circ_addr_gen.sv
module tb_dag_circ_addr_gen;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_bank = 2'd0, wr_idx = 2'd0, rd_bank = 2'd0, rd_idx = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic          acc_en = 1'b0;
  logic [1:0]    acc_ptr = 2'd0, acc_mod = 2'd0;
  logic [AW-1:0] rd_data, addr_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dag_circ_addr_gen #(.AW(AW), .NREG(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
    .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_out(addr_out)
  );

  // {pointer, modify, expected address}
  localparam logic [17:0] VEC [0:8] = '{
    {2'd0, 2'd0, 14'd100},   // R5: +3 inside buffer
    {2'd0, 2'd0, 14'd103},
    {2'd0, 2'd0, 14'd106},   // R5: 109 wraps to 101
    {2'd0, 2'd1, 14'd101},   // R6: 98 wraps to 106
    {2'd0, 2'd1, 14'd106},
    {2'd1, 2'd2, 14'h3FFE},  // R4: linear
    {2'd1, 2'd2, 14'h3FFF},  // R4: wraps to 0
    {2'd1, 2'd1, 14'h0000},  // R4: 0-3 gives 3FFD
    {2'd0, 2'd2, 14'd103}    // R3: modify chosen apart from pointer
  };

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] b, logic [1:0] i, logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] b, logic [1:0] i, logic [AW-1:0] exp);
    @(negedge clk);
    rd_bank = b; rd_idx = i;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic access(string tag, logic [1:0] p, logic [1:0] m, logic [AW-1:0] exp);
    @(negedge clk);
    acc_en = 1'b1; acc_ptr = p; acc_mod = m;
    #1 check(tag, addr_out, exp);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all banks
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 4; i++)
        rd("R1 reset value", 2'(b), 2'(i), '0);

    wr(2'd2, 2'd0, 14'd8);
    wr(2'd0, 2'd0, 14'd100);
    wr(2'd1, 2'd0, 14'd3);
    wr(2'd1, 2'd1, 14'h3FFD);
    wr(2'd1, 2'd2, 14'd1);
    wr(2'd0, 2'd1, 14'h3FFE);
    wr(2'd3, 2'd2, 14'h1234);   // R10: bank 3 write ignored
    rd("R3 modify readback", 2'd1, 2'd1, 14'h3FFD);
    rd("R10 bank 3 write ignored", 2'd1, 2'd2, 14'd1);
    rd("R10 bank 3 reads zero", 2'd3, 2'd2, '0);

    // R2: table of accesses, address is pre-update pointer
    for (int k = 0; k < 9; k++)
      access("R2 table address", VEC[k][17:16], VEC[k][15:14], VEC[k][13:0]);
    rd("R5 R6 pointer 0 after table", 2'd0, 2'd0, 14'd104);
    rd("R4 pointer 1 after table", 2'd0, 2'd1, 14'h3FFD);

    // R10: idle cycles hold
    repeat (3) @(negedge clk);
    rd("R10 idle hold", 2'd0, 2'd0, 14'd104);

    // R8: write and access to the same pointer
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'd0; wr_idx = 2'd2; wr_data = 14'd50;
    acc_en = 1'b1; acc_ptr = 2'd2; acc_mod = 2'd0;
    #1 check("R8 address before write", addr_out, 14'd0);
    @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
    rd("R8 write wins", 2'd0, 2'd2, 14'd50);

    // R9: write one pointer while accessing another
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'd0; wr_idx = 2'd3; wr_data = 14'd20;
    acc_en = 1'b1; acc_ptr = 2'd2; acc_mod = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
    rd("R9 accessed pointer stepped", 2'd0, 2'd2, 14'd53);
    rd("R9 written pointer loaded", 2'd0, 2'd3, 14'd20);

    // R7: length set after load; base stays at 50, buffer 50..54
    wr(2'd2, 2'd2, 14'd5);
    access("R7 step inside", 2'd2, 2'd2, 14'd53);
    access("R7 at top", 2'd2, 2'd2, 14'd54);
    rd("R7 wrapped to load base", 2'd0, 2'd2, 14'd50);

    // R1: reset again clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 pointer cleared", 2'd0, 2'd0, '0);
    rd("R1 length cleared", 2'd2, 2'd0, '0);

    finish_run();
  end
endmodule